// File: doc/BRIEF.md
# Frequency Offset Pulse Counter

This block estimates the carrier frequency offset of a received FSK signal. The demodulator emits a one-cycle strobe each time it decides a '1' (up strobe) and each time it decides a '0' (down strobe). A separate strobe marks every received symbol. Over a programmable window of symbols, the block accumulates a signed count of these strobes into an 8-bit two's-complement value.

Software, or a nearby controller, writes a 4-bit control word to start a measurement. The two low bits choose what is counted: nothing, up strobes, down strobes, or up minus down. The two high bits choose a window of 8, 16, 32 or 64 symbols. When the window is complete, the result register is loaded, the done flag rises and counting stops.

The strobes come from the demodulator and cannot be stalled, so the block has no back-pressure. Every input is sampled on every clock edge, and every strobe present on an edge is either counted or ignored by the mode rules. The result and done outputs are plain status levels that hold until the next measurement completes or the next control write.

Top module: `freq_offset_counter`

## Requirements
- R1: After reset, `result` is 0 and `done` is 0.
- R2: With mode `ctrl_data[1:0]`=01, each cycle with `up_pulse` high adds 1 to the count. `dn_pulse` has no effect.
- R3: With mode 10, each cycle with `dn_pulse` high subtracts 1 from the count. `up_pulse` has no effect, so the result is 0 or negative.
- R4: With mode 11, `up_pulse` adds 1 and `dn_pulse` subtracts 1. When both are high in the same cycle, the count is unchanged.
- R5: Window field `ctrl_data[3:2]` selects 00=8, 01=16, 10=32 or 11=64 `sym_tick` strobes. Strobes in the cycle of the final tick are still counted. `done` is high from the cycle after the final tick.
- R6: `result` holds the count as an 8-bit two's-complement number.
- R7: The count saturates at +127 and at -128 and never wraps.
- R8: Once `done` is high, further strobes and ticks change neither `result` nor `done` until the next control write.
- R9: A `ctrl_wr` with a non-zero mode clears the count and the tick count, lowers `done` and starts a new measurement. Strobes in the write cycle are not counted. A write during a measurement restarts it.
- R10: A `ctrl_wr` with mode 00 lowers `done` and leaves the block idle, and the previous `result` stays readable.
- R11: `result` changes only in the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_data | input | 4 | [1:0] mode, [3:2] window select |
| up_pulse | input | 1 | Demodulator '1' strobe |
| dn_pulse | input | 1 | Demodulator '0' strobe |
| sym_tick | input | 1 | One strobe per received symbol |
| result | output | 8 | Two's-complement count of the last finished measurement |
| done | output | 1 | High once a measurement has finished |

## Verification
The bench builds the block with its default parameters: an 8-bit result, a 2-bit window field and a 3-bit base window exponent. These defaults put every window length from 8 to 64 within reach. Dense strobe runs under a sparse tick rate drive the count into both saturation limits in the 64-symbol window, which the random runs would rarely reach. Random control writes land mid-window and on finished measurements, which covers restart and the off mode.

// File: rtl/foc_pkg.sv
package foc_pkg;
  typedef enum logic [1:0] {
    FOC_OFF  = 2'b00,
    FOC_UP   = 2'b01,
    FOC_DN   = 2'b10,
    FOC_BOTH = 2'b11
  } foc_mode_e;
endpackage

// File: rtl/foc_ctrl.sv
module foc_ctrl
  import foc_pkg::*;
#(
  parameter int WSEL_W = 2,
  localparam int CTRL_W = 2 + WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              last_sym,
  output foc_mode_e         mode,
  output logic [WSEL_W-1:0] wsel,
  output logic              run,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= FOC_OFF;
      wsel <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else if (wr) begin
      mode <= foc_mode_e'(wdata[1:0]);
      wsel <= wdata[CTRL_W-1:2];
      run  <= (wdata[1:0] != 2'b00);
      done <= 1'b0;
    end else if (run && last_sym) begin
      run  <= 1'b0;
      done <= 1'b1;
    end
  end

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[1:0] == 2'b00) |=> (!done && !run)); // R10
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !run); // R8
endmodule

// File: rtl/foc_window.sv
module foc_window #(
  parameter int WSEL_W   = 2,
  parameter int WIN_LOG0 = 3,
  localparam int NSEL  = 1 << WSEL_W,
  localparam int SYM_W = WIN_LOG0 + NSEL - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              sym_tick,
  input  logic [WSEL_W-1:0] wsel,
  output logic              last_sym
);
  logic [SYM_W-1:0] cnt;
  logic [SYM_W-1:0] last_idx [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_len
    assign last_idx[g] = SYM_W'((1 << (WIN_LOG0 + g)) - 1);
  end

  assign last_sym = run && !clr && sym_tick && (cnt == last_idx[wsel]);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (run && sym_tick && !last_sym) cnt <= cnt + 1'b1;
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= last_idx[wsel])); // R5
endmodule

// File: rtl/foc_accum.sv
module foc_accum
  import foc_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    run,
  input  foc_mode_e               mode,
  input  logic                    up,
  input  logic                    dn,
  output logic signed [RES_W-1:0] acc_next
);
  localparam logic signed [RES_W-1:0] ACC_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic signed [RES_W-1:0] ACC_MIN = {1'b1, {(RES_W-1){1'b0}}};

  logic signed [RES_W-1:0] acc;
  logic up_en, dn_en, inc, dec;

  assign up_en = up && mode[0];
  assign dn_en = dn && mode[1];
  assign inc   = up_en && !dn_en && (acc != ACC_MAX);
  assign dec   = dn_en && !up_en && (acc != ACC_MIN);

  always_comb begin
    acc_next = acc;
    if (clr)           acc_next = '0;
    else if (run) begin
      if (inc)         acc_next = acc + 1'b1;
      else if (dec)    acc_next = acc - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_next;
  end

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && acc == ACC_MAX && up && mode[0] && !(dn && mode[1])) |=> (acc == ACC_MAX)); // R7
  AST_UP_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FOC_UP) |-> !acc[RES_W-1]); // R2
  AST_DN_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == FOC_DN) |-> (acc[RES_W-1] || acc == '0)); // R3
endmodule

// File: rtl/freq_offset_counter.sv
module freq_offset_counter
  import foc_pkg::*;
#(
  parameter int RES_W    = 8,
  parameter int WSEL_W   = 2,
  parameter int WIN_LOG0 = 3,
  localparam int CTRL_W  = 2 + WSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_data,
  input  logic              up_pulse,
  input  logic              dn_pulse,
  input  logic              sym_tick,
  output logic [RES_W-1:0]  result,
  output logic              done
);
  foc_mode_e               mode;
  logic [WSEL_W-1:0]       wsel;
  logic                    run, last_sym;
  logic signed [RES_W-1:0] acc_next;

  foc_ctrl #(.WSEL_W(WSEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_data),
    .last_sym(last_sym), .mode(mode), .wsel(wsel), .run(run), .done(done)
  );

  foc_window #(.WSEL_W(WSEL_W), .WIN_LOG0(WIN_LOG0)) u_window (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_wr), .run(run),
    .sym_tick(sym_tick), .wsel(wsel), .last_sym(last_sym)
  );

  foc_accum #(.RES_W(RES_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_wr), .run(run), .mode(mode),
    .up(up_pulse), .dn(dn_pulse), .acc_next(acc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        result <= '0;
    else if (last_sym) result <= acc_next;
  end

  AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $rose(done)); // R11
endmodule

// File: tb/freq_offset_counter_bench.sv
module freq_offset_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr = 1'b0;
  logic [3:0] ctrl_data = '0;
  logic up_pulse = 1'b0, dn_pulse = 1'b0, sym_tick = 1'b0;
  logic [7:0] result;
  logic done;

  int n_checks = 0, n_errors = 0;
  int m_acc = 0, m_res = 0, m_cnt = 0, m_win = 8;
  bit m_run = 0, m_done = 0;
  logic [1:0] m_mode = 2'b00;

  freq_offset_counter u_freq_offset_counter (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
    .up_pulse(up_pulse), .dn_pulse(dn_pulse), .sym_tick(sym_tick),
    .result(result), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sat(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int step_of(input logic [1:0] md, input bit u, input bit d);
    int s = 0;
    if (u && md[0]) s++;
    if (d && md[1]) s--;
    return s;
  endfunction

  task automatic check(input int act, input int exp, input string req);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample_all();
    @(posedge clk); #1;
    check(int'(done), int'(m_done), "R5 done");
    check(int'($signed(result)), m_res, "R11 result");
  endtask

  task automatic cyc(input bit u, input bit d, input bit t);
    @(negedge clk);
    ctrl_wr = 1'b0; up_pulse = u; dn_pulse = d; sym_tick = t;
    if (m_run) begin
      m_acc = sat(m_acc + step_of(m_mode, u, d));
      if (t) begin
        m_cnt++;
        if (m_cnt == m_win) begin
          m_res = m_acc; m_run = 0; m_done = 1;
        end
      end
    end
    sample_all();
  endtask

  task automatic start(input logic [1:0] md, input logic [1:0] ws);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_data = {ws, md};
    up_pulse = 1'($urandom); dn_pulse = 1'($urandom); sym_tick = 1'($urandom);
    m_mode = md; m_win = 8 << ws; m_acc = 0; m_cnt = 0;
    m_run = (md != 2'b00); m_done = 0;
    sample_all();
  endtask

  task automatic run_rand(input int pu, input int pd, input int pt);
    int guard = 0;
    while (m_run && guard < 2000) begin
      cyc(($urandom % 100) < pu, ($urandom % 100) < pd, ($urandom % 100) < pt);
      guard++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(int'(result), 0, "R1 result");
    check(int'(done), 0, "R1 done");

    // R2: up only, down strobes present but ignored
    start(2'b01, 2'b00);
    repeat (40) begin
      if (!m_run) break;
      cyc(1, 1, ($urandom % 3) == 0);
    end
    run_rand(60, 60, 30);
    check(int'($signed(result)), m_res, "R2 up only");
    check(int'(m_res >= 0), 1, "R2 non-negative");

    // R3: down only, negative two's complement
    start(2'b10, 2'b01);
    run_rand(70, 70, 30);
    check(int'($signed(result)), m_res, "R3 down only");
    check(int'(result[7] || result == 0), 1, "R6 sign bit");

    // R4: simultaneous strobes cancel
    start(2'b11, 2'b00);
    while (m_run) cyc(1, 1, 1);
    check(int'($signed(result)), 0, "R4 cancel");

    // R5: exact window lengths, tick every cycle
    for (int w = 0; w < 4; w++) begin
      start(2'b01, 2'(w));
      for (int i = 0; i < (8 << w) - 1; i++) cyc(1, 0, 1);
      check(int'(done), 0, "R5 before last tick");
      cyc(1, 0, 1);
      check(int'(done), 1, "R5 after last tick");
      check(int'($signed(result)), 8 << w, "R5 count");
    end

    // R7: saturation high and low
    start(2'b01, 2'b11);
    while (m_run) cyc(1, 0, ($urandom % 4) == 0);
    check(int'($signed(result)), 127, "R7 high");
    start(2'b10, 2'b11);
    while (m_run) cyc(0, 1, ($urandom % 4) == 0);
    check(int'($signed(result)), -128, "R7 low");

    // R8: activity after done is ignored
    for (int i = 0; i < 20; i++) cyc(1, 0, 1);
    check(int'($signed(result)), -128, "R8 hold result");
    check(int'(done), 1, "R8 hold done");

    // R9: restart mid measurement
    start(2'b11, 2'b10);
    for (int i = 0; i < 15; i++) cyc(1, 0, 1);
    start(2'b01, 2'b00);
    check(int'(done), 0, "R9 done low");
    run_rand(50, 50, 50);
    check(int'($signed(result)), m_res, "R9 restart");

    // R10: off mode keeps previous result
    m_res = int'($signed(result));
    start(2'b00, 2'b00);
    for (int i = 0; i < 12; i++) cyc(1, 1, 1);
    check(int'(done), 0, "R10 done low");
    check(int'($signed(result)), m_res, "R10 result kept");

    // Random mix, including random restarts
    for (int k = 0; k < 40; k++) begin
      start(2'($urandom), 2'($urandom));
      if (($urandom % 4) == 0) begin
        for (int i = 0; i < 10; i++) cyc(1'($urandom), 1'($urandom), 1'($urandom));
        start(2'($urandom), 2'($urandom));
      end
      run_rand($urandom % 100, $urandom % 100, 20 + $urandom % 60);
      for (int i = 0; i < 3; i++) cyc(1'($urandom), 1'($urandom), 1'($urandom));
      check(int'($signed(result)), m_res, "R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule